// File: doc/BRIEF.md
# Byte-Command I2C Bus Master

This block is an I2C bus master that carries out exactly one byte-level bus operation for each command word that software writes. One command can open a transfer with a START and an address byte, shift out one data byte, shift in one data byte while answering with ACK or NACK, or close the transfer with a STOP. Software therefore sequences a whole message byte by byte. After each operation it reads a status word to learn the outcome: ownership, direction, acknowledge, lost arbitration, STOP and the byte seen on the bus.

Completion is signalled by a single-cycle interrupt pulse, and only when the command asked for one. The SCL and SDA pins are open-drain. Each is modelled as a pull-low enable plus an input that carries the resolved line. The bit timing comes from a clock register that holds the SCL period and its low-phase length in system-clock cycles. While SCL is released but still held low by another device, the bit counter waits. Between operations the master keeps SCL low, so the bus stays claimed until a STOP is issued.

Register indexes on the 2-bit address are: 0 command (write), 1 status (read), 2 clock (read/write).

Top module: `i2c_byte_master`

## Requirements
- R1: After reset, both pins are released and no interrupt is pending. The status word reads 0x0100, meaning only bus-free (bit 8) is set.
- R2: The clock register at index 2 holds the SCL period in bits 15:0 and the low-phase length in bits 31:16, and it reads back as written. Within each bit, SCL is pulled low for exactly the low-phase count of cycles and released for the remaining cycles of the period.
- R3: A command with bit 10 set (and bit 9 clear) sends a START and then bits 7:0 as the address byte, MSB first, with bit 0 giving the direction (1 = read). Afterwards the status shows master (bit 14) and transmitting (bit 13), and bits 7:0 hold the byte seen on SDA.
- R4: A command with bits 10 and 9 clear, issued after a write address, shifts bits 7:0 out MSB first. The addressed device receives that byte, and status bits 7:0 echo it.
- R5: A command with bits 10 and 9 clear, issued after a read address, shifts in one byte that appears in status bits 7:0 with bit 13 clear. The master answers ACK when bit 8 is clear and NACK when bit 8 is set.
- R6: Status bit 11 (no ACK) takes the level of SDA sampled in the ninth clock of every transmitted byte. It is set when the address is not acknowledged.
- R7: A command with bit 9 set issues only a STOP. Afterwards both pins are released, and the status shows STOP seen (bit 12) and bus free (bit 8), with master and transmitting cleared.
- R8: Each finished operation produces exactly one single-cycle interrupt pulse, and only when bit 11 of its command was set.
- R9: If SDA reads low while the master leaves it released during a transmitted bit, the master sets arbitration lost (bit 9), releases both pins at once and ends the operation without a STOP.
- R10: While the clock period is zero, a command write is ignored: no bus activity, no interrupt, and no status change.
- R11: A command written while an operation is in progress is ignored, so the running operation completes as commanded and only one pulse results.
- R12: A command written in the same cycle as the completion pulse is accepted and carried out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index: 0 command, 1 status, 2 clock |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the addressed register |
| irq | output | 1 | One-cycle completion pulse |
| scl_oe | output | 1 | Pull SCL low when 1 |
| scl_in | input | 1 | Resolved SCL line level |
| sda_oe | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | Resolved SDA line level |

## Verification
The completion pulse and the next command write can land in the same cycle. This is the case in which software reacts at once to the pulse. The bench waits for the pulse and drives a STOP command in that very cycle. It then judges acceptance from a second pulse and from the STOP status. As a contrast, a write issued mid-operation must leave the running operation and its status untouched.

// File: rtl/i2cb_pkg.sv
package i2cb_pkg;
  // command word fields
  localparam int CMD_W   = 12;
  localparam int C_IEN   = 11;
  localparam int C_START = 10;
  localparam int C_STOP  = 9;
  localparam int C_NOACK = 8;
  // status word fields
  localparam int ST_W    = 16;
  localparam int S_OWN   = 14;
  localparam int S_TX    = 13;
  localparam int S_STOP  = 12;
  localparam int S_NAK   = 11;
  localparam int S_ARB   = 9;
  localparam int S_FREE  = 8;
  // register indexes
  localparam logic [1:0] RA_CMD  = 2'd0;
  localparam logic [1:0] RA_STAT = 2'd1;
  localparam logic [1:0] RA_CLK  = 2'd2;
  localparam int HALF_LSB = 16;

  typedef enum logic [2:0] {
    PH_IDLE, PH_START, PH_BIT, PH_ACK, PH_STOP
  } phase_e;
endpackage

// File: rtl/i2cb_regs.sv
module i2cb_regs
  import i2cb_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr,
  input  logic [1:0]           addr,
  input  logic [31:0]          wdata,
  input  logic                 busy,
  input  logic [ST_W-1:0]      status,
  output logic [31:0]          rdata,
  output logic                 accept,
  output logic [CMD_W-1:0]     cmd,
  output logic [CNT_W-1:0]     per,
  output logic [CNT_W-1:0]     half
);
  logic [CNT_W-1:0] per_q, per_d, half_q, half_d;
  logic             clk_we;

  always_comb begin
    clk_we = wr && (addr == RA_CLK) && !busy;
    per_d  = per_q;
    half_d = half_q;
    if (clk_we) begin
      per_d  = wdata[CNT_W-1:0];
      half_d = wdata[HALF_LSB +: CNT_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q  <= '0;
      half_q <= '0;
    end else if (clk_we) begin
      per_q  <= per_d;
      half_q <= half_d;
    end
  end

  always_comb begin
    accept = wr && (addr == RA_CMD) && !busy && (per_q != '0);
    cmd    = wdata[CMD_W-1:0];
    per    = per_q;
    half   = half_q;
    rdata  = '0;
    case (addr)
      RA_STAT: rdata[ST_W-1:0] = status;
      RA_CLK: begin
        rdata[CNT_W-1:0]           = per_q;
        rdata[HALF_LSB +: CNT_W]   = half_q;
      end
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/i2cb_timer.sv
module i2cb_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             hold,
  input  logic [CNT_W-1:0] per,
  input  logic [CNT_W-1:0] half,
  output logic             ev_drive,
  output logic             ev_rise,
  output logic             ev_samp,
  output logic             ev_end
);
  logic [CNT_W-1:0] cnt_q, cnt_d, samp_pt;

  always_comb begin
    samp_pt  = half + ((per - half) >> 1);
    ev_drive = run && (cnt_q == (half >> 1));
    ev_rise  = run && (cnt_q == half - 1'b1);
    ev_samp  = run && !hold && (cnt_q == samp_pt);
    ev_end   = run && !hold && (cnt_q == per - 1'b1);
    cnt_d    = cnt_q;
    if (!run)        cnt_d = '0;
    else if (hold)   cnt_d = cnt_q;
    else if (ev_end) cnt_d = '0;
    else             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/i2cb_engine.sv
module i2cb_engine
  import i2cb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_op,
  input  logic [CMD_W-1:0]  cmd,
  input  logic              ev_drive,
  input  logic              ev_rise,
  input  logic              ev_samp,
  input  logic              ev_end,
  input  logic              sda_in,
  output logic              busy,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              irq,
  output logic              op_ien,
  output logic              op_sup,
  output logic [ST_W-1:0]   status
);
  phase_e     ph_q, ph_d;
  logic [2:0] bit_q, bit_d;
  logic [7:0] sh_q, sh_d;
  logic busy_q, busy_d, rd_q, rd_d, own_q, own_d, tx_q, tx_d;
  logic stp_q, stp_d, nak_q, nak_d, arb_q, arb_d;
  logic scl_q, scl_d, sda_q, sda_d, irq_q, irq_d, ien_q, ien_d, sup_q, sup_d;

  always_comb begin
    ph_d = ph_q;   bit_d = bit_q; sh_d = sh_q;   busy_d = busy_q;
    rd_d = rd_q;   own_d = own_q; tx_d = tx_q;   stp_d = stp_q;
    nak_d = nak_q; arb_d = arb_q; scl_d = scl_q; sda_d = sda_q;
    ien_d = ien_q; sup_d = sup_q; irq_d = 1'b0;
    if (start_op) begin
      busy_d = 1'b1; scl_d = 1'b1;
      stp_d = 1'b0;  nak_d = 1'b0; arb_d = 1'b0;
      ien_d = cmd[C_IEN]; sup_d = cmd[C_NOACK];
      if (cmd[C_STOP]) begin
        ph_d = PH_STOP; tx_d = 1'b0;
      end else if (cmd[C_START]) begin
        ph_d = PH_START; sh_d = cmd[7:0]; rd_d = cmd[0]; tx_d = 1'b1;
      end else begin
        ph_d = PH_BIT; bit_d = 3'd7; sh_d = cmd[7:0]; tx_d = !rd_q;
      end
    end else if (busy_q) begin
      if (ev_drive) begin
        case (ph_q)
          PH_START: sda_d = 1'b0;
          PH_STOP:  sda_d = 1'b1;
          PH_BIT:   sda_d = tx_q ? !sh_q[7] : 1'b0;
          PH_ACK:   sda_d = tx_q ? 1'b0 : !sup_q;
          default:  sda_d = sda_q;
        endcase
      end
      if (ev_rise) scl_d = 1'b0;
      if (ev_samp) begin
        case (ph_q)
          PH_START: begin sda_d = 1'b1; own_d = 1'b1; end
          PH_STOP:  sda_d = 1'b0;
          PH_BIT: begin
            sh_d = {sh_q[6:0], sda_in};
            if (tx_q && !sda_q && !sda_in) begin
              arb_d = 1'b1; scl_d = 1'b0; sda_d = 1'b0; own_d = 1'b0;
              tx_d = 1'b0; busy_d = 1'b0; ph_d = PH_IDLE; irq_d = ien_q;
            end
          end
          PH_ACK:   if (tx_q) nak_d = sda_in;
          default:  ;
        endcase
      end
      if (ev_end && busy_d) begin
        case (ph_q)
          PH_START: begin ph_d = PH_BIT; bit_d = 3'd7; scl_d = 1'b1; end
          PH_BIT: begin
            scl_d = 1'b1;
            if (bit_q == 3'd0) ph_d = PH_ACK;
            else               bit_d = bit_q - 3'd1;
          end
          PH_ACK: begin
            scl_d = 1'b1; busy_d = 1'b0; ph_d = PH_IDLE; irq_d = ien_q;
          end
          PH_STOP: begin
            scl_d = 1'b0; busy_d = 1'b0; ph_d = PH_IDLE; irq_d = ien_q;
            own_d = 1'b0; stp_d = 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_IDLE; bit_q <= '0;   sh_q <= '0;   busy_q <= 1'b0;
      rd_q <= 1'b0;    own_q <= 1'b0; tx_q <= 1'b0; stp_q <= 1'b0;
      nak_q <= 1'b0;   arb_q <= 1'b0; scl_q <= 1'b0; sda_q <= 1'b0;
      irq_q <= 1'b0;   ien_q <= 1'b0; sup_q <= 1'b0;
    end else begin
      ph_q <= ph_d;    bit_q <= bit_d; sh_q <= sh_d; busy_q <= busy_d;
      rd_q <= rd_d;    own_q <= own_d; tx_q <= tx_d; stp_q <= stp_d;
      nak_q <= nak_d;  arb_q <= arb_d; scl_q <= scl_d; sda_q <= sda_d;
      irq_q <= irq_d;  ien_q <= ien_d; sup_q <= sup_d;
    end
  end

  always_comb begin
    busy   = busy_q;
    scl_oe = scl_q;
    sda_oe = sda_q;
    irq    = irq_q;
    op_ien = ien_q;
    op_sup = sup_q;
    status = '0;
    status[7:0]    = sh_q;
    status[S_OWN]  = own_q;
    status[S_TX]   = tx_q;
    status[S_STOP] = stp_q;
    status[S_NAK]  = nak_q;
    status[S_ARB]  = arb_q;
    status[S_FREE] = !own_q && !busy_q;
  end
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
  import i2cb_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq,
  output logic        scl_oe,
  input  logic        scl_in,
  output logic        sda_oe,
  input  logic        sda_in
);
  logic [1:0]        rs_q;
  logic              rst_sn;
  logic              busy, accept, hold, op_ien, op_sup;
  logic              ev_drive, ev_rise, ev_samp, ev_end;
  logic [CMD_W-1:0]  cmd;
  logic [CNT_W-1:0]  per, half;
  logic [ST_W-1:0]   status_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sn = rs_q[1];

  // a released SCL still read low means another device stretches the clock
  assign hold = !scl_oe && !scl_in;

  i2cb_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_sn), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .busy(busy), .status(status_w), .rdata(reg_rdata),
    .accept(accept), .cmd(cmd), .per(per), .half(half)
  );

  i2cb_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_sn), .run(busy), .hold(hold), .per(per),
    .half(half), .ev_drive(ev_drive), .ev_rise(ev_rise),
    .ev_samp(ev_samp), .ev_end(ev_end)
  );

  i2cb_engine u_eng (
    .clk(clk), .rst_n(rst_sn), .start_op(accept), .cmd(cmd),
    .ev_drive(ev_drive), .ev_rise(ev_rise), .ev_samp(ev_samp),
    .ev_end(ev_end), .sda_in(sda_in), .busy(busy), .scl_oe(scl_oe),
    .sda_oe(sda_oe), .irq(irq), .op_ien(op_ien), .op_sup(op_sup),
    .status(status_w)
  );
endmodule

// File: rtl/i2c_byte_master_chk.sv
module i2c_byte_master_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic [1:0]       reg_addr,
  input logic [CNT_W-1:0] per,
  input logic             busy,
  input logic             irq,
  input logic             op_ien,
  input logic             op_sup,
  input logic             arb,
  input logic             stopd,
  input logic             scl_oe,
  input logic             sda_oe
);
  a_r8_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  a_r8_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> op_ien);
  a_r8_irq_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !busy);
  a_r10_zero_period: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd0 && per == '0 && !busy) |=> !busy);
  a_r11_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr && reg_addr == 2'd0) |=> ($stable({op_ien, op_sup}) && busy));
  a_r9_arb_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arb) |-> (!scl_oe && !sda_oe && !busy));
  a_r7_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stopd) |-> (!scl_oe && !sda_oe));
endmodule

bind i2c_byte_master i2c_byte_master_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_sn), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .per(per), .busy(busy), .irq(irq), .op_ien(op_ien), .op_sup(op_sup),
  .arb(status_w[9]), .stopd(status_w[12]), .scl_oe(scl_oe), .sda_oe(sda_oe)
);

// File: tb/i2c_byte_master_test.sv
`timescale 1ns/1ps
module i2c_byte_master_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq, scl_oe, sda_oe;
  logic        s_drive = 1'b0, force_low = 1'b0;
  wire         scl_line = !scl_oe;
  wire         sda_line = !(sda_oe || s_drive || force_low);
  int          n_tests = 0, n_fail = 0;

  always #5 clk = ~clk;

  i2c_byte_master uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .scl_oe(scl_oe), .scl_in(scl_line), .sda_oe(sda_oe), .sda_in(sda_line)
  );

  // ---------------- simple target device at address 0x2A ----------------
  localparam logic [6:0] SADDR = 7'h2A;
  logic       s_act = 1'b0, s_skip = 1'b0, s_inaddr = 1'b0, s_rd = 1'b0;
  logic       s_match = 1'b0, s_mack = 1'b0;
  logic [7:0] s_sh = '0, s_last = '0;
  int         s_bits = 0, s_bidx = 0;

  function automatic logic [7:0] rbyte(int i);
    return (i == 0) ? 8'hA5 : 8'h3C;
  endfunction

  always @(negedge sda_line) if (scl_line === 1'b1) begin
    s_act = 1'b1; s_skip = 1'b1; s_bits = 0; s_inaddr = 1'b1; s_drive = 1'b0;
  end
  always @(posedge sda_line) if (scl_line === 1'b1 && s_act) begin
    s_act = 1'b0; s_drive = 1'b0;
  end
  always @(posedge scl_line) if (s_act) begin
    if (s_bits < 8) s_sh = {s_sh[6:0], sda_line};
    else            s_mack = !sda_line;
  end
  always @(negedge scl_line) if (s_act) begin
    logic [7:0] b;
    if (s_skip) s_skip = 1'b0;
    else if (s_bits < 8) begin
      s_bits++;
      if (s_bits == 8) begin
        if (s_inaddr)   s_drive = (s_sh[7:1] == SADDR);
        else if (!s_rd) begin
          s_drive = s_match;
          if (s_match) s_last = s_sh;
        end else        s_drive = 1'b0;
      end else if (!s_inaddr && s_rd && s_match) begin
        b = rbyte(s_bidx); s_drive = !b[7 - s_bits];
      end
    end else begin
      s_bits = 0; s_drive = 1'b0;
      if (s_inaddr) begin
        s_inaddr = 1'b0; s_match = (s_sh[7:1] == SADDR); s_rd = s_sh[0];
        s_mack = 1'b1; s_bidx = 0;
      end else if (s_rd) s_bidx++;
      if (s_rd && s_match && s_mack) begin
        b = rbyte(s_bidx); s_drive = !b[7];
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd_stat(output logic [15:0] v);
    reg_addr = 2'd1; #1; v = reg_rdata[15:0];
  endtask

  task automatic count_irq(input int cyc, output int n);
    n = 0;
    repeat (cyc) begin @(negedge clk); if (irq) n++; end
  endtask

  task automatic run_op(input logic [11:0] c, input logic [15:0] exp, input string tag);
    int n; logic [15:0] st;
    wr(2'd0, {20'd0, c});
    count_irq(300, n);
    chk(n == int'(c[11]), "R8 pulse count", n, c[11]);
    rd_stat(st);
    chk(st == exp, tag, st, exp);
  endtask

  // {command[11:0], expected status[15:0]}
  localparam logic [27:0] VEC [12] = '{
    28'hC54_6054, 28'h99E_609E, 28'hB00_119E, 28'hC55_6055,
    28'h800_40A5, 28'h900_403C, 28'hB00_113C, 28'hC40_6840,
    28'hB00_1140, 28'h454_6054, 28'h9C1_60C1, 28'hB00_11C1
  };

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] st; int n, hi, lo, k;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    rd_stat(st);
    chk(st == 16'h0100, "R1 status after reset", st, 16'h0100);
    chk({scl_oe, sda_oe, irq} == 3'b000, "R1 pins released", {scl_oe, sda_oe, irq}, 0);
    // R10 zero period: command ignored
    wr(2'd0, 32'hC54);
    count_irq(100, n);
    chk(n == 0, "R10 no pulse with zero period", n, 0);
    chk(scl_oe == 1'b0, "R10 no bus activity", scl_oe, 0);
    rd_stat(st);
    chk(st == 16'h0100, "R10 status unchanged", st, 16'h0100);
    // R2 clock register
    wr(2'd2, {16'd8, 16'd20});
    reg_addr = 2'd2; #1;
    chk(reg_rdata == 32'h0008_0014, "R2 clock readback", reg_rdata, 32'h0008_0014);
    // table of operations
    for (int i = 0; i < 12; i++) begin
      logic [11:0] c; c = VEC[i][27:16];
      if (c[9])       run_op(c, VEC[i][15:0], "R7 stop status");
      else if (c[10]) run_op(c, VEC[i][15:0], "R3 R6 address status");
      else            run_op(c, VEC[i][15:0], "R4 R5 data status");
    end
    chk(s_last == 8'hC1, "R4 byte received by device", s_last, 8'hC1);
    chk({scl_oe, sda_oe} == 2'b00, "R7 lines released after stop", {scl_oe, sda_oe}, 0);
    // R2 SCL low/high split
    wr(2'd0, 32'h454);
    while (scl_oe) @(negedge clk);
    hi = 0; while (!scl_oe) begin hi++; @(negedge clk); end
    lo = 0; while (scl_oe)  begin lo++; @(negedge clk); end
    chk(hi == 12, "R2 SCL high cycles", hi, 12);
    chk(lo == 8, "R2 SCL low cycles", lo, 8);
    repeat (300) @(negedge clk);
    run_op(12'hB00, 16'h1154, "R7 stop after timing probe");
    // R11 write while busy ignored
    wr(2'd0, 32'hC54);
    repeat (20) @(negedge clk);
    wr(2'd0, 32'hB00);
    count_irq(300, n);
    chk(n == 1, "R11 single pulse", n, 1);
    rd_stat(st);
    chk(st == 16'h6054, "R11 stop write ignored", st, 16'h6054);
    run_op(12'hB00, 16'h1154, "R7 stop after busy test");
    // R12 write in the cycle of the completion pulse
    wr(2'd0, 32'hC54);
    k = 0;
    while (!irq && k < 500) begin @(negedge clk); k++; end
    reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 32'hB00;
    @(negedge clk); reg_wr = 1'b0;
    count_irq(300, n);
    chk(n == 1, "R12 write at pulse accepted", n, 1);
    rd_stat(st);
    chk(st == 16'h1154, "R12 stop carried out", st, 16'h1154);
    // R9 arbitration lost
    force_low = 1'b1;
    wr(2'd0, 32'hC54);
    count_irq(300, n);
    chk(n == 1, "R9 pulse on arbitration loss", n, 1);
    rd_stat(st);
    chk(st[15:8] == 8'h03, "R9 status flags", st[15:8], 8'h03);
    chk({scl_oe, sda_oe} == 2'b00, "R9 lines released", {scl_oe, sda_oe}, 0);
    force_low = 1'b0;
    repeat (10) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule